// File: doc/BRIEF.md
# Legacy Low-Memory Route Decoder

This block decides, for each memory access from the processor side, whether the access is served by system DRAM or is forwarded to the PCI bus. It covers the legacy area below 1 MB. That area contains thirteen shadow regions, whose read and write paths can each be pointed at DRAM or PCI separately, and the 128 KB system-management window at 0xA0000–0xBFFFF. Above those regions a single top-of-memory limit splits DRAM from PCI.

Software sets up the routing through a small configuration space, addressed by dword with byte enables. Seven attribute bytes at offsets 0x59–0x5F hold one nibble per shadow region. One control byte at offset 0x72 sets how the system-management window is seen: an open bit, a closed bit, a lock bit and a global enable. An access is presented with its address, direction and a system-management-mode flag, and the routing answer is registered one cycle later.

Top module: `lowmem_route_top`

## Requirements
- R1: After reset all attribute bytes read 0x00, the control byte at 0x72 reads 0x02, and a read of 0xF0000 is routed to PCI.
- R2: The configuration port is dword addressed (`cfg_addr` = byte offset / 4) with per-byte enables. Bytes 0x59–0x5F and 0x72 are stored and read back. Every other byte reads 0x00 and ignores writes, so byte 0x58 reads 0x00.
- R3: Region 0 spans 0xF0000–0xFFFFF and uses the high nibble of byte 0x59. Expansion region i (1..12) spans 0xC0000 + (i−1)·0x4000 for 16 KB and uses byte 0x59 + (i+1)/2: the low nibble when i is odd, the high nibble when i is even.
- R4: Inside a region, nibble bit 0 set routes reads to DRAM and nibble bit 1 set routes writes to DRAM. A clear bit routes that direction to PCI.
- R5: A non-SMM access to 0xA0000–0xBFFFF goes to DRAM only when the open bit (bit 6 of byte 0x72) is set; otherwise it goes to PCI.
- R6: An SMM access to 0xA0000–0xBFFFF goes to DRAM exactly when the global enable (bit 3 of 0x72) is set, whatever the open bit holds.
- R7: Once the lock bit (bit 4 of 0x72) is set, it stays set until reset and the open bit reads 0 and cannot be set. A write that sets lock and open together leaves open at 0. The closed bit (bit 5) and the global enable remain writable.
- R8: Bits 2:0 of byte 0x72 always read 010 and bit 7 always reads 0, whatever is written.
- R9: An access outside the window and the shadow regions goes to DRAM when its address is below `TOP_OF_MEM` and to PCI when it is at or above it.
- R10: `rsp_valid` and `rsp_to_dram` appear on the clock edge after the edge that accepts `acc_valid`. An access accepted on the same edge as a configuration write is routed with the settings that were in place before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data, byte lane n = offset 4·addr+n |
| cfg_rdata | output | 32 | Combinational read data of the addressed dword |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_smm | input | 1 | Access issued in system-management mode |
| rsp_valid | output | 1 | Routing answer valid |
| rsp_to_dram | output | 1 | 1 = DRAM, 0 = PCI |

## Verification
A configuration write and an access decode can land on the same clock edge. The bench provokes this by driving, in one cycle, a write that opens the management window together with a non-SMM access into that window. It expects the access to go to PCI, because the routing uses the old settings, and it then expects a follow-up access one cycle later to go to DRAM. The lock tests also interleave writes with accesses, which confirms that a forbidden open request never changes the routing.

// File: rtl/lowmem_pkg.sv
// Shared constants and helper functions for the low-memory route decoder.
// Assumes a 256-byte configuration space addressed as 64 dwords.
package lowmem_pkg;
    localparam int unsigned NUM_EXP     = 12;
    localparam int unsigned NUM_REGIONS = NUM_EXP + 1;
    localparam int unsigned ATTR_BYTES  = (NUM_REGIONS + 1) / 2;
    localparam int unsigned ATTR_OFF    = 'h59;
    localparam int unsigned SMCTL_OFF   = 'h72;

    localparam logic [31:0] BIOS_BASE = 32'h000F_0000;
    localparam logic [31:0] BIOS_SIZE = 32'h0001_0000;
    localparam logic [31:0] EXP_BASE  = 32'h000C_0000;
    localparam logic [31:0] EXP_SIZE  = 32'h0000_4000;
    localparam logic [31:0] WIN_BASE  = 32'h000A_0000;
    localparam logic [31:0] WIN_SIZE  = 32'h0002_0000;

    localparam int unsigned SM_OPEN   = 6;
    localparam int unsigned SM_CLOSED = 5;
    localparam int unsigned SM_LOCK   = 4;
    localparam int unsigned SM_GEN    = 3;
    localparam logic [7:0]  SM_RESET  = 8'h02;
    localparam logic [2:0]  SM_FIXED  = 3'b010;

    function automatic logic [31:0] region_base(int unsigned g);
        return (g == 0) ? BIOS_BASE : EXP_BASE + (g - 1) * EXP_SIZE;
    endfunction

    function automatic logic [31:0] region_size(int unsigned g);
        return (g == 0) ? BIOS_SIZE : EXP_SIZE;
    endfunction

    function automatic int unsigned attr_byte(int unsigned g);
        return (g + 1) / 2;
    endfunction

    function automatic bit attr_high(int unsigned g);
        return (g == 0) || (g % 2 == 0);
    endfunction
endpackage

// File: rtl/lowmem_cfg_regs.sv
// Configuration register file: seven attribute bytes and the window control
// byte. Assumes dword addressing with byte enables; unmapped bytes read zero.
module lowmem_cfg_regs
    import lowmem_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [5:0]               cfg_addr,
    input  logic [3:0]               cfg_be,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    output logic [NUM_REGIONS*2-1:0] region_rw,
    output logic                     win_open,
    output logic                     win_gen,
    output logic [7:0]               smctl_q
);
    logic [7:0] attr_q [ATTR_BYTES];
    logic [7:0] lane_addr [4];
    logic [7:0] smctl_nxt;
    logic       smctl_we;
    logic [7:0] smctl_wbyte;

    // Byte offset carried by each lane of the addressed dword.
    always_comb begin
        for (int l = 0; l < 4; l++) lane_addr[l] = {cfg_addr, 2'(l)};
    end

    // Locate the lane (if any) that targets the window control byte.
    always_comb begin
        smctl_we    = 1'b0;
        smctl_wbyte = 8'h00;
        for (int l = 0; l < 4; l++) begin
            if (cfg_wr && cfg_be[l] && int'(lane_addr[l]) == SMCTL_OFF) begin
                smctl_we    = 1'b1;
                smctl_wbyte = cfg_wdata[l*8 +: 8];
            end
        end
    end

    // Apply the lock and fixed-bit rules to a control byte write.
    always_comb begin
        smctl_nxt            = 8'h00;
        smctl_nxt[2:0]       = SM_FIXED;
        smctl_nxt[SM_LOCK]   = smctl_q[SM_LOCK] | smctl_wbyte[SM_LOCK];
        smctl_nxt[SM_OPEN]   = smctl_wbyte[SM_OPEN] & ~smctl_nxt[SM_LOCK];
        smctl_nxt[SM_CLOSED] = smctl_wbyte[SM_CLOSED];
        smctl_nxt[SM_GEN]    = smctl_wbyte[SM_GEN];
    end

    // Store the attribute bytes from enabled lanes that hit their offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ATTR_BYTES; k++) attr_q[k] <= 8'h00;
        end else if (cfg_wr) begin
            for (int l = 0; l < 4; l++) begin
                for (int k = 0; k < ATTR_BYTES; k++) begin
                    if (cfg_be[l] && int'(lane_addr[l]) == ATTR_OFF + k)
                        attr_q[k] <= cfg_wdata[l*8 +: 8];
                end
            end
        end
    end

    // Store the window control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        smctl_q <= SM_RESET;
        else if (smctl_we) smctl_q <= smctl_nxt;
    end

    // Return the addressed dword, zero for unmapped bytes.
    always_comb begin
        cfg_rdata = '0;
        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < ATTR_BYTES; k++) begin
                if (int'(lane_addr[l]) == ATTR_OFF + k) cfg_rdata[l*8 +: 8] = attr_q[k];
            end
            if (int'(lane_addr[l]) == SMCTL_OFF) cfg_rdata[l*8 +: 8] = smctl_q;
        end
    end

    // Pick each region's read/write enable pair out of its nibble.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rw
        localparam int unsigned BI = attr_byte(g);
        localparam int unsigned SH = attr_high(g) ? 4 : 0;
        assign region_rw[g*2 +: 2] = attr_q[BI][SH +: 2];
    end

    assign win_open = smctl_q[SM_OPEN];
    assign win_gen  = smctl_q[SM_GEN];
endmodule

// File: rtl/lowmem_attr_decode.sv
// Shadow-region decoder: finds which of the thirteen regions an address falls
// in and applies that region's read or write enable. Assumes ADDR_W >= 20.
module lowmem_attr_decode
    import lowmem_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic                     acc_write,
    input  logic [NUM_REGIONS*2-1:0] region_rw,
    output logic                     reg_hit,
    output logic                     reg_dram
);
    logic [NUM_REGIONS-1:0] hit;
    logic [NUM_REGIONS-1:0] allow;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(region_base(g));
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(region_base(g) + region_size(g));
        // Range match and direction-selected enable for one region.
        assign hit[g]   = (acc_addr >= LO) && (acc_addr < HI);
        assign allow[g] = acc_write ? region_rw[g*2+1] : region_rw[g*2];
    end

    assign reg_hit  = |hit;
    assign reg_dram = |(hit & allow);
endmodule

// File: rtl/lowmem_smram_view.sv
// Management window decoder: non-SMM accesses see DRAM only when the window
// is open; SMM accesses see DRAM only when the global enable is set.
module lowmem_smram_view
    import lowmem_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    input  logic              win_open,
    input  logic              win_gen,
    output logic              win_hit,
    output logic              win_dram
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_BASE + WIN_SIZE);

    // Window match and mode-dependent view.
    assign win_hit  = (acc_addr >= LO) && (acc_addr < HI);
    assign win_dram = acc_smm ? win_gen : win_open;
endmodule

// File: rtl/lowmem_route_top.sv
// Top of the low-memory route decoder. Priority: management window, then
// shadow regions, then top-of-memory split. The answer is registered once.
module lowmem_route_top
    import lowmem_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] TOP_OF_MEM = 'h0800_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [5:0]        cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_smm,
    output logic              rsp_valid,
    output logic              rsp_to_dram
);
    logic [NUM_REGIONS*2-1:0] region_rw;
    logic                     win_open, win_gen, win_hit, win_dram;
    logic                     reg_hit, reg_dram, route_dram;
    logic [7:0]               smctl_q;

    lowmem_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .region_rw(region_rw), .win_open(win_open), .win_gen(win_gen),
        .smctl_q(smctl_q)
    );

    lowmem_attr_decode #(.ADDR_W(ADDR_W)) u_attr (
        .acc_addr(acc_addr), .acc_write(acc_write), .region_rw(region_rw),
        .reg_hit(reg_hit), .reg_dram(reg_dram)
    );

    lowmem_smram_view #(.ADDR_W(ADDR_W)) u_win (
        .acc_addr(acc_addr), .acc_smm(acc_smm), .win_open(win_open),
        .win_gen(win_gen), .win_hit(win_hit), .win_dram(win_dram)
    );

    // Combine the three decoders in priority order.
    always_comb begin
        if (win_hit)      route_dram = win_dram;
        else if (reg_hit) route_dram = reg_dram;
        else              route_dram = (acc_addr < TOP_OF_MEM);
    end

    // Register the routing answer for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_to_dram <= 1'b0;
        end else begin
            rsp_valid   <= acc_valid;
            rsp_to_dram <= acc_valid ? route_dram : 1'b0;
        end
    end
endmodule

// File: rtl/lowmem_route_chk.sv
// Checker for the low-memory route decoder, attached to the top by bind.
// Assumes the control byte register is visible as smctl_q in the top.
module lowmem_route_chk
    import lowmem_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] TOP_OF_MEM = 'h0800_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        cfg_addr,
    input logic [31:0]       cfg_rdata,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_smm,
    input logic              rsp_valid,
    input logic              rsp_to_dram,
    input logic [7:0]        smctl_q
);
    logic in_win;
    assign in_win = (acc_addr >= ADDR_W'(WIN_BASE)) && (acc_addr < ADDR_W'(WIN_BASE + WIN_SIZE));

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid); // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid); // R10
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        smctl_q[SM_LOCK] |=> smctl_q[SM_LOCK]); // R7
    AST_LOCK_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        smctl_q[SM_LOCK] |=> !smctl_q[SM_OPEN]); // R7
    AST_WIN_SHUT_NONSMM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_smm && in_win && !smctl_q[SM_OPEN]) |=> !rsp_to_dram); // R5
    AST_WIN_SMM_NOGEN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_smm && in_win && !smctl_q[SM_GEN]) |=> !rsp_to_dram); // R6
    AST_ABOVE_TOP_PCI: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr >= TOP_OF_MEM) |=> !rsp_to_dram); // R9
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'h1C) |-> (cfg_rdata[18:16] == SM_FIXED && !cfg_rdata[23])); // R8
endmodule

bind lowmem_route_top lowmem_route_chk #(.ADDR_W(ADDR_W), .TOP_OF_MEM(TOP_OF_MEM)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_smm(acc_smm),
    .rsp_valid(rsp_valid), .rsp_to_dram(rsp_to_dram), .smctl_q(smctl_q)
);

// File: tb/test_lowmem_route_top.sv
// Directed bench for the low-memory route decoder.
module test_lowmem_route_top;
    localparam int unsigned ADDR_W = 32;
    localparam logic [31:0] TOP    = 32'h0800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_smm = 1'b0;
    logic        rsp_valid, rsp_to_dram;
    int          n_cmp = 0, n_bad = 0;

    always #2 clk = ~clk;

    lowmem_route_top #(.ADDR_W(ADDR_W), .TOP_OF_MEM(TOP)) i_lowmem_route_top (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_smm(acc_smm), .rsp_valid(rsp_valid), .rsp_to_dram(rsp_to_dram)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [5:0] a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic set_smctl(logic [7:0] v);
        cfg_write(6'h1C, 4'b0100, {8'h00, v, 16'h0000});
    endtask

    task automatic access(logic [31:0] a, logic w, logic s, output logic dram);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_smm = s;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R10 rsp_valid", 32'(rsp_valid), 32'd1);
        dram = rsp_to_dram;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic r;
        cfg_read(6'h16, d); check("R1 attr dword 0x58", d, 32'h0);
        cfg_read(6'h17, d); check("R1 attr dword 0x5C", d, 32'h0);
        cfg_read(6'h1C, d); check("R1 ctl dword 0x70", d, 32'h0002_0000);
        check("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
        access(32'hF0000, 1'b0, 1'b0, r); check("R1 bios read to PCI", 32'(r), 32'd0);
    endtask

    task automatic t_cfg_space();
        logic [31:0] d;
        cfg_write(6'h16, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'h16, d); check("R2 byte 0x58 unmapped", d, 32'hFFFF_FF00);
        cfg_write(6'h10, 4'hF, 32'hDEAD_BEEF);
        cfg_read(6'h10, d); check("R2 unmapped dword", d, 32'h0);
        cfg_write(6'h17, 4'b0101, 32'h1122_3344);
        cfg_read(6'h17, d); check("R2 byte enables", d, 32'h0022_0044);
        cfg_write(6'h16, 4'hF, 32'h0);
        cfg_write(6'h17, 4'hF, 32'h0);
    endtask

    task automatic program_nibble(int g, logic [3:0] v);
        logic [7:0] b [7];
        for (int k = 0; k < 7; k++) b[k] = 8'h00;
        if (g == 0 || g % 2 == 0) b[(g + 1) / 2][7:4] = v;
        else                      b[(g + 1) / 2][3:0] = v;
        cfg_write(6'h16, 4'b1110, {b[2], b[1], b[0], 8'h00});
        cfg_write(6'h17, 4'b1111, {b[6], b[5], b[4], b[3]});
    endtask

    task automatic t_regions();
        logic r;
        for (int g = 0; g < 13; g++) begin
            logic [31:0] base, size, nbase;
            int ng;
            base = (g == 0) ? 32'hF0000 : 32'hC0000 + 32'(g - 1) * 32'h4000;
            size = (g == 0) ? 32'h10000 : 32'h4000;
            ng = (g + 1) % 13;
            nbase = (ng == 0) ? 32'hF0000 : 32'hC0000 + 32'(ng - 1) * 32'h4000;
            program_nibble(g, 4'h1);
            access(base, 1'b0, 1'b0, r);            check($sformatf("R3 region %0d first byte", g), 32'(r), 32'd1);
            access(base + size - 1, 1'b0, 1'b0, r); check($sformatf("R3 region %0d last byte", g), 32'(r), 32'd1);
            access(base, 1'b1, 1'b0, r);            check($sformatf("R4 region %0d write to PCI", g), 32'(r), 32'd0);
            access(nbase, 1'b0, 1'b0, r);           check($sformatf("R3 region %0d neighbour", g), 32'(r), 32'd0);
        end
        program_nibble(0, 4'h2);
        access(32'hF8000, 1'b1, 1'b0, r); check("R4 write enable to DRAM", 32'(r), 32'd1);
        access(32'hF8000, 1'b0, 1'b0, r); check("R4 read stays PCI", 32'(r), 32'd0);
        program_nibble(0, 4'h0);
    endtask

    task automatic t_window();
        logic r;
        logic [31:0] d;
        set_smctl(8'hC5);
        cfg_read(6'h1C, d); check("R8 fixed and reserved bits", d, 32'h0042_0000);
        access(32'hA0000, 1'b0, 1'b0, r); check("R5 open non-SMM DRAM", 32'(r), 32'd1);
        access(32'hA0000, 1'b0, 1'b1, r); check("R6 SMM without enable PCI", 32'(r), 32'd0);
        set_smctl(8'h08);
        access(32'hBFFFF, 1'b1, 1'b0, r); check("R5 closed non-SMM PCI", 32'(r), 32'd0);
        access(32'hBFFFF, 1'b1, 1'b1, r); check("R6 SMM with enable DRAM", 32'(r), 32'd1);
        access(32'hC0000, 1'b0, 1'b1, r); check("R3 past window is region", 32'(r), 32'd0);
    endtask

    task automatic t_outside();
        logic r;
        access(32'h0005_0000, 1'b0, 1'b0, r); check("R9 low DRAM", 32'(r), 32'd1);
        access(TOP - 1, 1'b1, 1'b0, r);      check("R9 below top", 32'(r), 32'd1);
        access(TOP, 1'b0, 1'b0, r);          check("R9 at top PCI", 32'(r), 32'd0);
    endtask

    task automatic t_same_cycle();
        logic r;
        set_smctl(8'h00);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 6'h1C; cfg_be = 4'b0100; cfg_wdata = 32'h0040_0000;
        acc_valid = 1'b1; acc_addr = 32'hA4000; acc_write = 1'b0; acc_smm = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0; acc_valid = 1'b0;
        check("R10 same-cycle uses old setting", 32'(rsp_to_dram), 32'd0);
        access(32'hA4000, 1'b0, 1'b0, r); check("R10 next access new setting", 32'(r), 32'd1);
    endtask

    task automatic t_lock();
        logic r;
        logic [31:0] d;
        set_smctl(8'h58);
        cfg_read(6'h1C, d); check("R7 lock with open", d, 32'h001A_0000);
        set_smctl(8'h40);
        cfg_read(6'h1C, d); check("R7 open refused, lock kept", d, 32'h0012_0000);
        access(32'hA0000, 1'b0, 1'b0, r); check("R7 locked window PCI", 32'(r), 32'd0);
        set_smctl(8'h28);
        cfg_read(6'h1C, d); check("R7 closed and enable writable", d, 32'h003A_0000);
        access(32'hA0000, 1'b0, 1'b1, r); check("R7 SMM after lock DRAM", 32'(r), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg_space();
        t_regions();
        t_window();
        t_outside();
        t_same_cycle();
        t_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule